// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a digital model of a clock output stage with four sections of two outputs each. It runs on a fast time-unit clock whose rate is N times the nominal output frequency. A modulo-N phase counter on that clock sets the zero-skew position. Each section then builds its waveform from that count. A section can shift its output by a whole number of time units, or act as a divider or an inverter. A frequency-range select picks N, which is 44, 26 or 16 ticks per nominal period.

Each section has two selects, F1 and F0. Each select carries an already decoded three-level code. The nine code pairs map to different function sets in different sections. Sections 1 and 2 offer fine skews. Sections 3 and 4 offer coarse skews, and in place of their extreme codes they offer divide-by-2, divide-by-4 or an inverted output. A test select bypasses the generated timing: the reference input then drives every output, filtered only by the section's own function. Select and range changes are held back until the next period boundary, so no runt pulse is produced mid-period.

Top module: `skew_clock_matrix`

## Requirements
- R1: The range select sets the period N in time-unit ticks. The codes are 2'b00 = LOW with N=44, 2'b01 = MID with N=26, 2'b10 = HIGH with N=16, and 2'b11 is treated as MID.
- R2: Each section select is 4 bits, {F1[1:0], F0[1:0]}. Each level uses the range code encoding (00 LOW, 01 MID, 10 HIGH, 11 read as MID). The index is idx = 3*F1 + F0, from 0 to 8.
- R3: Sections 1 and 2 output a skew of idx-4 time units, so the codes LL through HH give -4 up to +4.
- R4: In section 3, idx 0 (LL) gives divide-by-2 and idx 8 (HH) gives divide-by-4. Idx 1 to 7 give a skew of 2*idx-8, which is -6 to +6 in steps of 2.
- R5: In section 4, idx 0 gives divide-by-2 and idx 8 gives an inverted zero-phase output, whose rising edge lies N/2 ticks after the zero-skew rise. Idx 1 to 7 give the same skews as section 3.
- R6: The two outputs of a section are always equal. A section at MM rises at the same tick as any other section at MM.
- R7: A skew of k places the rising edge (k mod N) ticks after the zero-skew rise, so a negative k is earlier. A skewed or inverted output repeats every N ticks and is high for N/2 of them.
- R8: A divide-by-2 output has period 2N and a divide-by-4 output has period 4N. Both rise on a zero-skew rise, both have a 50% duty cycle, and every falling edge of a divide-by-4 output coincides with a falling edge of a divide-by-2 output.
- R9: A change of the range or of any select takes effect only at the next period boundary. The waveform in progress finishes unchanged.
- R10: Reset is synchronous and active low. All outputs are low during reset and in the first cycle after release. A section at MM is high in the second cycle after release.
- R11: With the test select not LOW (00), each skew-function output equals the reference input one clock later, and an inverted output equals its complement. Divide-by-2 toggles on each falling reference edge, and divide-by-4 toggles on every second one, with its falls aligned to divide-by-2 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-unit clock, N ticks per nominal period |
| rst_n | input | 1 | Synchronous active-low reset |
| range_sel | input | 2 | Frequency-range code, sets N |
| test_sel | input | 2 | Test code; any value but LOW bypasses generated timing |
| ref_in | input | 1 | Reference level used in test bypass |
| sel_p1 | input | 4 | Section 1 select {F1,F0} |
| sel_p2 | input | 4 | Section 2 select {F1,F0} |
| sel_p3 | input | 4 | Section 3 select {F1,F0} |
| sel_p4 | input | 4 | Section 4 select {F1,F0} |
| q_p1 | output | 2 | Section 1 output pair |
| q_p2 | output | 2 | Section 2 output pair |
| q_p3 | output | 2 | Section 3 output pair |
| q_p4 | output | 2 | Section 4 output pair |

## Verification
The bench builds the block with its default periods of 44, 26 and 16 ticks and drives all three range codes, along with the 2'b11 alias. The shortest period gives the tightest spacing between edges, and the longest pushes a divide-by-4 waveform out to 176 ticks, which still fits in a capture window. With a small period N, the negative skews wrap modulo N close to the period boundary. This brings the wrap-around offsets and the fall alignment of the dividers within reach of a sweep over every code on every section.

// File: rtl/skew_matrix_pkg.sv
// Package: shared types and select decoding for the skew clock matrix.
// Assumes selects arrive as already decoded two-bit three-level codes.
package skew_matrix_pkg;

    typedef enum logic [1:0] {
        FN_SKEW = 2'd0,
        FN_DIV2 = 2'd1,
        FN_DIV4 = 2'd2,
        FN_INV  = 2'd3
    } fn_e;

    typedef struct packed {
        fn_e               fn;
        logic signed [4:0] skew;
    } pair_cfg_t;

    // Fold the unused code 2'b11 onto MID.
    function automatic logic [1:0] lvl_norm(input logic [1:0] c);
        return (c == 2'b11) ? 2'b01 : c;
    endfunction

    // Map {F1,F0} to the index 0..8 (LL first, HH last).
    function automatic logic [3:0] sel_index(input logic [3:0] sel);
        logic [3:0] f1;
        logic [3:0] f0;
        f1 = {2'b00, lvl_norm(sel[3:2])};
        f0 = {2'b00, lvl_norm(sel[1:0])};
        return f1 * 4'd3 + f0;
    endfunction

    // Per-section function table; sections 1-2 fine, 3-4 coarse with specials.
    function automatic pair_cfg_t decode_sel(input int section, input logic [3:0] sel);
        pair_cfg_t  c;
        logic [3:0] idx;
        idx    = sel_index(sel);
        c.fn   = FN_SKEW;
        c.skew = 5'sd0;
        if (section <= 2) begin
            c.skew = $signed({1'b0, idx}) - 5'sd4;
        end else if (idx == 4'd0) begin
            c.fn = FN_DIV2;
        end else if (idx == 4'd8) begin
            c.fn = (section == 3) ? FN_DIV4 : FN_INV;
        end else begin
            c.skew = ($signed({1'b0, idx}) <<< 1) - 5'sd8;
        end
        return c;
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
// Phase generator: modulo-N tick counter, period index for the dividers,
// and the configuration latch that only updates at the period boundary.
// Assumes every N value is even and larger than 12.
module skew_phase_gen #(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16,
    parameter int CW     = 6,
    parameter int SELW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      range_sel,
    input  logic [SELW-1:0] sel_bus,
    output logic [CW-1:0]   cnt_o,
    output logic [CW-1:0]   n_o,
    output logic [1:0]      pcnt_o,
    output logic            running_o,
    output logic [SELW-1:0] sel_o
);

    logic [CW-1:0]   cnt;
    logic [CW-1:0]   n_act;
    logic [1:0]      pcnt;
    logic            running;
    logic [SELW-1:0] sel_l;
    logic            wrap;

    // Range code to ticks per period; 2'b11 reads as MID.
    function automatic logic [CW-1:0] n_of(input logic [1:0] r);
        case (r)
            2'b00:   return CW'(N_LOW);
            2'b10:   return CW'(N_HIGH);
            default: return CW'(N_MID);
        endcase
    endfunction

    // Last tick of the current period.
    assign wrap = running && (cnt == n_act - 1'b1);

    // Advance the counter; latch range and selects only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            n_act   <= n_of(2'b01);
            pcnt    <= 2'd0;
            running <= 1'b0;
            sel_l   <= '0;
        end else if (!running || wrap) begin
            cnt     <= '0;
            n_act   <= n_of(range_sel);
            sel_l   <= sel_bus;
            running <= 1'b1;
            pcnt    <= running ? pcnt + 2'd1 : 2'd0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cnt_o     = cnt;
    assign n_o       = n_act;
    assign pcnt_o    = pcnt;
    assign running_o = running;
    assign sel_o     = sel_l;

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < n_act));

    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(sel_l) && $stable(n_act)));

    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> $stable(pcnt));

endmodule

// File: rtl/skew_ref_div.sv
// Reference divider for test bypass: counts falling reference edges so the
// divide-by-2 and divide-by-4 bits fall together. Outputs are next-state bits.
module skew_ref_div (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic div2_nx,
    output logic div4_nx
);

    logic       ref_d;
    logic [1:0] tcnt;
    logic [1:0] tcnt_nx;
    logic       fall;

    // Falling edge of the reference as seen at this clock edge.
    assign fall    = ref_d & ~ref_in;
    assign tcnt_nx = tcnt + {1'b0, fall};
    assign div2_nx = tcnt_nx[0];
    assign div4_nx = tcnt_nx[1];

    // Track the previous reference level and the fall count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            tcnt  <= 2'd0;
        end else begin
            ref_d <= ref_in;
            tcnt  <= tcnt_nx;
        end
    end

endmodule

// File: rtl/skew_pair_out.sv
// One output section: decodes its latched select, builds the timed waveform
// from the shared phase count, or the bypass waveform from the reference.
// Assumes cnt < n_act and that n_act is even.
module skew_pair_out
    import skew_matrix_pkg::*;
#(
    parameter int SECTION = 1,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] n_act,
    input  logic [1:0]    pcnt,
    input  logic          running,
    input  logic          test_act,
    input  logic          ref_in,
    input  logic          ref_div2,
    input  logic          ref_div4,
    input  logic [3:0]    sel,
    output logic [1:0]    q
);

    pair_cfg_t   cfg;
    logic [3:0]  mag;
    logic [CW:0] s_mod;
    logic [CW:0] ph_raw;
    logic [CW:0] ph;
    logic [CW:0] half;
    logic        base_hi;
    logic        zero_hi;
    logic        wave;
    logic        twave;
    logic        q_bit;

    assign cfg = decode_sel(SECTION, sel);

    // Skew folded into 0..N-1, then phase of this tick relative to it.
    always_comb begin
        mag     = cfg.skew[4] ? 4'(-cfg.skew) : cfg.skew[3:0];
        s_mod   = cfg.skew[4] ? ({1'b0, n_act} - (CW+1)'(mag)) : (CW+1)'(mag);
        ph_raw  = {1'b0, cnt} + {1'b0, n_act} - s_mod;
        ph      = (ph_raw >= {1'b0, n_act}) ? ph_raw - {1'b0, n_act} : ph_raw;
        half    = {2'b00, n_act[CW-1:1]};
        base_hi = (ph < half);
        zero_hi = ({1'b0, cnt} < half);
    end

    // Select the timed waveform for this section's function.
    always_comb begin
        case (cfg.fn)
            FN_DIV2: wave = pcnt[0];
            FN_DIV4: wave = pcnt[1];
            FN_INV:  wave = ~zero_hi;
            default: wave = base_hi;
        endcase
    end

    // Select the bypass waveform derived from the reference.
    always_comb begin
        case (cfg.fn)
            FN_DIV2: twave = ref_div2;
            FN_DIV4: twave = ref_div4;
            FN_INV:  twave = ~ref_in;
            default: twave = ref_in;
        endcase
    end

    // Output register shared by both pins of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
        end else if (!running) begin
            q_bit <= 1'b0;
        end else if (test_act) begin
            q_bit <= twave;
        end else begin
            q_bit <= wave;
        end
    end

    assign q = {2{q_bit}};

    p_low_before_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !q_bit);

    p_test_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && test_act && cfg.fn == FN_SKEW) |=> (q_bit == $past(ref_in)));

endmodule

// File: rtl/skew_clock_matrix.sv
// Top: four output sections sharing one phase generator and one reference
// divider. Assumes clk is the time-unit clock (N ticks per nominal period).
module skew_clock_matrix #(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] range_sel,
    input  logic [1:0] test_sel,
    input  logic       ref_in,
    input  logic [3:0] sel_p1,
    input  logic [3:0] sel_p2,
    input  logic [3:0] sel_p3,
    input  logic [3:0] sel_p4,
    output logic [1:0] q_p1,
    output logic [1:0] q_p2,
    output logic [1:0] q_p3,
    output logic [1:0] q_p4
);

    localparam int NPAIR = 4;
    localparam int SELW  = 4 * NPAIR;
    localparam int N_MAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                           : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
    localparam int CW    = $clog2(N_MAX + 1);

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    n_act;
    logic [1:0]       pcnt;
    logic             running;
    logic [SELW-1:0]  sel_l;
    logic             test_act;
    logic             ref_div2;
    logic             ref_div4;
    logic [2*NPAIR-1:0] q_all;

    assign test_act = (test_sel != 2'b00);

    skew_phase_gen #(
        .N_LOW (N_LOW),
        .N_MID (N_MID),
        .N_HIGH(N_HIGH),
        .CW    (CW),
        .SELW  (SELW)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .range_sel(range_sel),
        .sel_bus  ({sel_p4, sel_p3, sel_p2, sel_p1}),
        .cnt_o    (cnt),
        .n_o      (n_act),
        .pcnt_o   (pcnt),
        .running_o(running),
        .sel_o    (sel_l)
    );

    skew_ref_div u_refdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .div2_nx(ref_div2),
        .div4_nx(ref_div4)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        skew_pair_out #(
            .SECTION(g + 1),
            .CW     (CW)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .n_act   (n_act),
            .pcnt    (pcnt),
            .running (running),
            .test_act(test_act),
            .ref_in  (ref_in),
            .ref_div2(ref_div2),
            .ref_div4(ref_div4),
            .sel     (sel_l[4*g +: 4]),
            .q       (q_all[2*g +: 2])
        );
    end

    assign q_p1 = q_all[1:0];
    assign q_p2 = q_all[3:2];
    assign q_p3 = q_all[5:4];
    assign q_p4 = q_all[7:6];

endmodule

// File: tb/skew_clock_matrix_bench.sv
`timescale 1ns/1ps
module skew_clock_matrix_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] range_sel = 2'b01;
    logic [1:0] test_sel = 2'b00;
    logic       ref_in = 1'b0;
    logic [3:0] sel_p1 = 4'b0101;
    logic [3:0] sel_p2 = 4'b0101;
    logic [3:0] sel_p3 = 4'b0101;
    logic [3:0] sel_p4 = 4'b0101;
    logic [1:0] q_p1, q_p2, q_p3, q_p4;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit tmode = 1'b0;

    logic [7:0] smp [0:511];
    logic       rs  [0:511];

    always #2.5 clk = ~clk;

    skew_clock_matrix u_skew_clock_matrix (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .test_sel(test_sel),
        .ref_in(ref_in), .sel_p1(sel_p1), .sel_p2(sel_p2), .sel_p3(sel_p3),
        .sel_p4(sel_p4), .q_p1(q_p1), .q_p2(q_p2), .q_p3(q_p3), .q_p4(q_p4)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_of(input int r);
        if (r == 0) return 44;
        if (r == 2) return 16;
        return 26;
    endfunction

    function automatic int lvl(input int c);
        return (c == 3) ? 1 : c;
    endfunction

    // Expected kind: 0 skew, 1 div2, 2 div4, 3 inverted.
    function automatic int exp_kind(input int p, input int idx);
        if (p <= 2) return 0;
        if (idx == 0) return 1;
        if (idx == 8) return (p == 3) ? 2 : 3;
        return 0;
    endfunction

    function automatic int exp_skew(input int p, input int idx);
        if (p <= 2) return idx - 4;
        return 2 * idx - 8;
    endfunction

    function automatic logic [3:0] code_of(input int idx);
        logic [1:0] a, b;
        a = 2'(idx / 3);
        b = 2'(idx % 3);
        return {a, b};
    endfunction

    function automatic int first_rise(input int o, input int from, input int len);
        for (int i = (from < 1 ? 1 : from); i < len; i++)
            if (smp[i][o] && !smp[i-1][o]) return i;
        return -1;
    endfunction

    function automatic int first_fall(input int o, input int from, input int len);
        for (int i = (from < 1 ? 1 : from); i < len; i++)
            if (!smp[i][o] && smp[i-1][o]) return i;
        return -1;
    endfunction

    task automatic capture(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            smp[i] = {q_p4, q_p3, q_p2, q_p1};
            rs[i]  = ref_in;
            if (tmode) ref_in = ((i % 6) < 2) ? 1'b1 : 1'b0;
        end
    endtask

    task automatic apply(input int r, input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] c, input logic [3:0] d);
        @(negedge clk);
        range_sel = 2'(r);
        sel_p1 = a; sel_p2 = b; sel_p3 = c; sel_p4 = d;
        repeat (100) @(negedge clk);
    endtask

    // Measure pair p against reference output bit refo.
    task automatic eval_pair(input int p, input int idx, input int n, input int refo, input int len);
        int to, tr, tt, t2, k, kind, eoff, eper, hi;
        string tag;
        bit same;
        to   = 2 * (p - 1);
        kind = exp_kind(p, idx);
        k    = exp_skew(p, idx);
        tag  = (p <= 2) ? "R3" : ((p == 3) ? "R4" : "R5");
        if (kind == 1 || kind == 2) tag = "R8";
        eper = (kind == 1) ? 2 * n : ((kind == 2) ? 4 * n : n);
        eoff = (kind == 3) ? n / 2 : ((kind == 0) ? ((k % n) + n) % n : 0);
        tr = first_rise(refo, 1, len);
        tt = (tr < 0) ? -1 : first_rise(to, tr, len);
        t2 = (tt < 0) ? -1 : first_rise(to, tt + 1, len);
        if (t2 < 0) begin
            chk(1'b0, {tag, " edges present"}, t2, 0);
            return;
        end
        chk(((tt - tr) % n) == eoff, {tag, " R7 rise offset"}, (tt - tr) % n, eoff);
        chk((t2 - tt) == eper, {tag, " R1 period"}, t2 - tt, eper);
        hi = 0;
        for (int i = tt; i < t2; i++) hi += smp[i][to];
        chk(hi == eper / 2, {tag, " R7 duty"}, hi, eper / 2);
        same = 1'b1;
        for (int i = 0; i < len; i++) if (smp[i][to] != smp[i][to+1]) same = 1'b0;
        chk(same, "R6 pair outputs equal", same, 1);
    endtask

    // Every fall of output a (div4) must coincide with a fall of output b (div2).
    task automatic fall_align(input int a, input int b, input int len, input string tag);
        int nf;
        bit ok;
        ok = 1'b1;
        nf = 0;
        for (int i = 1; i < len; i++)
            if (!smp[i][a] && smp[i-1][a]) begin
                nf++;
                if (!(!smp[i][b] && smp[i-1][b])) ok = 1'b0;
            end
        chk(ok && nf > 0, {tag, " divided falls aligned"}, nf, 1);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_v, n, rp, len, t1, t2, f1, f0, idx;
        logic [3:0] cs [1:4];
        int ids [1:4];
        seed_v = $urandom(32'd4242);

        // R10: outputs low in reset, in the first cycle after release, MM high next.
        repeat (5) @(negedge clk);
        chk({q_p4, q_p3, q_p2, q_p1} == 8'h00, "R10 low during reset", {q_p4, q_p3, q_p2, q_p1}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({q_p4, q_p3, q_p2, q_p1} == 8'h00, "R10 low first cycle", {q_p4, q_p3, q_p2, q_p1}, 0);
        @(negedge clk);
        chk(q_p1 == 2'b11, "R10 MM high second cycle", q_p1, 3);

        // R6: all sections at MM are aligned.
        apply(1, 4'b0101, 4'b0101, 4'b0101, 4'b0101);
        capture(60);
        t1 = 1;
        for (int i = 0; i < 60; i++)
            if (smp[i] != 8'h00 && smp[i] != 8'hFF) t1 = 0;
        chk(t1 == 1, "R6 all MM aligned", t1, 1);

        // Directed sweep: every code on every section in every range (R2-R5, R7, R8).
        for (int r = 0; r < 3; r++) begin
            n = n_of(r);
            len = 9 * n + 4;
            for (int p = 1; p <= 4; p++) begin
                for (int c = 0; c < 9; c++) begin
                    for (int j = 1; j <= 4; j++) cs[j] = 4'b0101;
                    cs[p] = code_of(c);
                    apply(r, cs[1], cs[2], cs[3], cs[4]);
                    capture(len);
                    eval_pair(p, c, n, (p == 1) ? 2 : 0, len);
                end
            end
        end

        // R8: divide-by-4 on section 3 and divide-by-2 on section 4 together.
        for (int r = 0; r < 3; r++) begin
            n = n_of(r);
            apply(r, 4'b0101, 4'b0101, 4'b1010, 4'b0000);
            capture(9 * n + 4);
            fall_align(4, 6, 9 * n + 4, "R8");
        end

        // Random mix with alias codes (R1, R2): one reference at MM, others random.
        for (int t = 0; t < 30; t++) begin
            int r;
            r = int'($urandom_range(3, 0));
            n = n_of(r);
            len = 9 * n + 4;
            rp = int'($urandom_range(4, 1));
            for (int j = 1; j <= 4; j++) begin
                f1 = int'($urandom_range(3, 0));
                f0 = int'($urandom_range(3, 0));
                cs[j]  = {2'(f1), 2'(f0)};
                ids[j] = 3 * lvl(f1) + lvl(f0);
            end
            cs[rp] = 4'b1101;
            ids[rp] = 4;
            apply(r, cs[1], cs[2], cs[3], cs[4]);
            capture(len);
            for (int j = 1; j <= 4; j++)
                if (j != rp) eval_pair(j, ids[j], n, 2 * (rp - 1), len);
            if (ids[3] == 8 && ids[4] == 0) fall_align(4, 6, len, "R8 random");
        end

        // R9: a select change mid-period leaves the current period unchanged.
        apply(2, 4'b0101, 4'b0101, 4'b0101, 4'b0101);
        n = 16;
        t1 = 0;
        begin
            logic prev;
            prev = q_p1[0];
            while (t1 == 0) begin
                @(negedge clk);
                if (q_p1[0] && !prev) t1 = 1;
                prev = q_p1[0];
            end
        end
        @(negedge clk);
        @(negedge clk);
        sel_p2 = 4'b1001;
        t2 = 1;
        for (int i = 3; i < n; i++) begin
            @(negedge clk);
            if (q_p2 != q_p1) t2 = 0;
        end
        chk(t2 == 1, "R9 period finishes unchanged", t2, 1);
        repeat (60) @(negedge clk);
        capture(9 * n + 4);
        eval_pair(2, 7, n, 0, 9 * n + 4);

        // R11: test bypass, pass-through and dividers.
        apply(1, 4'b0101, 4'b0000, 4'b1010, 4'b0000);
        test_sel = 2'b10;
        tmode = 1'b1;
        capture(120);
        t1 = 1;
        for (int i = 2; i < 120; i++)
            if (smp[i][0] != rs[i] || smp[i][2] != rs[i]) t1 = 0;
        chk(t1 == 1, "R11 skew sections follow ref", t1, 1);
        t1 = first_rise(4, 2, 120);
        t2 = (t1 < 0) ? -1 : first_rise(4, t1 + 1, 120);
        chk(t2 - t1 == 24, "R11 div4 period in bypass", t2 - t1, 24);
        t1 = first_rise(6, 2, 120);
        t2 = (t1 < 0) ? -1 : first_rise(6, t1 + 1, 120);
        chk(t2 - t1 == 12, "R11 div2 period in bypass", t2 - t1, 12);
        fall_align(4, 6, 120, "R11");
        t1 = first_fall(6, 2, 120);
        chk(t1 > 0 && !rs[t1] && rs[t1-1], "R11 div2 falls with ref", t1, 1);

        @(negedge clk);
        tmode = 1'b0;
        test_sel = 2'b00;
        apply(1, 4'b0101, 4'b0101, 4'b0000, 4'b1010);
        test_sel = 2'b01;
        tmode = 1'b1;
        capture(120);
        t1 = 1;
        for (int i = 2; i < 120; i++)
            if (smp[i][6] != ~rs[i]) t1 = 0;
        chk(t1 == 1, "R11 inverted section in bypass", t1, 1);
        t1 = first_rise(4, 2, 120);
        t2 = (t1 < 0) ? -1 : first_rise(4, t1 + 1, 120);
        chk(t2 - t1 == 12, "R11 section 3 div2 in bypass", t2 - t1, 12);
        tmode = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule